// File: doc/BRIEF.md
# Burst Preamble Phase Estimator

This block watches a stream of oversampled line samples, one word of W samples per clock, while a burst preamble arrives. It finds every place where two neighbouring samples differ, including the seam between the last sample of the previous word and the first sample of the current one. It sorts each such transition into a phase bin: the sample's position counted from the start of the burst, modulo the integer oversampling ratio. Each clock's bin counts are pushed into a short history. A programmable window of the most recent 1, 2, 4 or 8 clocks is summed into a histogram over the bins.

When the end-of-preamble strobe arrives, the block freezes the estimate. The fullest bin is taken as the edge phase. The sampling phase half a bit period away from it is latched for a downstream bit picker. A one-cycle valid pulse announces it, and the value is held until the next burst starts. Only the tail of the preamble counts toward the result. If the window contains no transitions at all, the previous phase is kept and an error flag is raised instead.

Control is a three-state machine. IDLE is entered at reset. ACQUIRE is entered from any state on a burst-start pulse, and a new burst-start while in ACQUIRE restarts it. HOLD is entered from ACQUIRE when the end-of-preamble strobe arrives, and it is left only on the next burst-start.

Top module: `burst_phase_est`

## Requirements
- R1: After reset the block is in IDLE, with phase_o = 0, phase_vld_o = 0, locked_o = 0 and no_edge_err_o = 0.
- R2: Sample bit 0 of samp_i is the earliest sample in time. A transition is counted at each sample that differs from the sample just before it, and the last sample of the previous word serves as the predecessor of bit 0. The transition's bin is its sample index counted from the first word after the burst-start cycle, modulo osr_i.
- R3: win_sel_i chooses the averaging window: 0 gives 1 clock, 1 gives 2, 2 gives 4 and 3 gives 8. Only the words of the last window-length clocks before the end-of-preamble cycle are counted, and the word presented in the end-of-preamble cycle is not counted.
- R4: The edge phase is the bin with the most transitions in the window, and a tie goes to the lowest bin. The latched phase is (edge + floor(osr_i/2)) mod osr_i.
- R5: When eop_i is high in ACQUIRE, the next cycle shows phase_vld_o = 1 for exactly one cycle, locked_o = 1 and the new phase_o.
- R6: In HOLD, phase_o does not change. An eop_i pulse in IDLE or HOLD produces no valid pulse and leaves phase_o unchanged.
- R7: A burst-start pulse empties the history, restarts the sample index at 0, clears locked_o and no_edge_err_o, and enters ACQUIRE. phase_o keeps its previous value.
- R8: If the window holds no transitions at end of preamble, phase_o keeps its previous value, no_edge_err_o becomes 1, and phase_vld_o still pulses.
- R9: Oversampling ratios of 5, 6 and 10 give correct phases with W = 80 and with W = 32, including word widths that are not a multiple of the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_start_i | input | 1 | One-cycle pulse that starts a new burst acquisition |
| eop_i | input | 1 | End-of-preamble strobe, high in the first non-preamble cycle |
| osr_i | input | PW | Integer oversampling ratio (5 to MAX_OSR) |
| win_sel_i | input | 2 | Averaging window select (1, 2, 4 or 8 clocks) |
| samp_i | input | W | Oversampled line samples, bit 0 earliest |
| phase_o | output | PW | Latched sampling phase, 0 to osr_i-1 |
| phase_vld_o | output | 1 | One-cycle pulse when a new phase is latched |
| locked_o | output | 1 | High while a burst phase is held |
| no_edge_err_o | output | 1 | The last latch found no transitions in its window |

## Verification
The bench switches the preamble phase partway through a burst so that only a tail of the new phase sits before the strobe. A window that is too long, too short, or that counts the strobe cycle's word would then report the old phase. It latches a burst and starts a new short one with a full window. A design that leaves the history in place across burst-start would then return the stale phase. A 32-sample instance runs beside the 80-sample one at ratios 5, 6 and 10. A design that fails to carry the sample index across words would smear the bins there and land on a wrong phase. Stray strobes in IDLE and HOLD, and a silent preamble, check that the valid pulse and the held value behave as stated and are not overwritten.

// File: rtl/burst_phase_pkg.sv
package burst_phase_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_HOLD = 2'd2
    } bp_state_e;

    localparam int WIN_SEL_W = 2;
    localparam int MAX_WIN   = 8;
endpackage

// File: rtl/bp_edge_bins.sv
module bp_edge_bins #(
    parameter int W       = 80,
    parameter int MAX_OSR = 10,
    parameter int PW      = 4,
    parameter int CW      = 7
) (
    input  logic [W-1:0]                word_i,
    input  logic                        prev_i,
    input  logic [PW-1:0]               osr_i,
    input  logic [PW-1:0]               off_i,
    output logic [MAX_OSR-1:0][CW-1:0]  cnt_o,
    output logic [PW-1:0]               off_nxt_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TW = CW + 4;

    logic [PW-1:0] pos_v;
    logic          last_v;
    logic [TW-1:0] tot_v;

    // walk the word sample by sample, carrying the bin position
    always_comb begin
        cnt_o  = '0;
        pos_v  = off_i;
        last_v = prev_i;
        for (int i = 0; i < W; i++) begin
            if (word_i[i] != last_v) begin
                for (int k = 0; k < MAX_OSR; k++) begin
                    if (pos_v == PW'(k)) begin
                        cnt_o[k] = cnt_o[k] + CW'(1);
                    end
                end
            end
            last_v = word_i[i];
            if (pos_v >= osr_i - PW'(1)) begin
                pos_v = '0;
            end else begin
                pos_v = pos_v + PW'(1);
            end
        end
        off_nxt_o = pos_v;
    end

    always_comb begin
        tot_v = '0;
        for (int k = 0; k < MAX_OSR; k++) begin
            tot_v = tot_v + TW'(cnt_o[k]);
        end
    end

    // R2
    always_comb begin
        if (osr_i >= PW'(5) && off_i < osr_i) begin
            bin_bound_chk: assert (tot_v <= TW'(W) && off_nxt_o < osr_i);
        end
    end
endmodule

// File: rtl/bp_hist_window.sv
module bp_hist_window
    import burst_phase_pkg::*;
#(
    parameter int W       = 80,
    parameter int MAX_OSR = 10,
    parameter int DEPTH   = 8,
    parameter int CW      = 7,
    parameter int SW      = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        shift_i,
    input  logic [WIN_SEL_W-1:0]        win_sel_i,
    input  logic [MAX_OSR-1:0][CW-1:0]  cnt_i,
    output logic [MAX_OSR-1:0][SW-1:0]  sum_o,
    output logic [SW-1:0]               total_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LW = $clog2(MAX_WIN + 1) + 1;

    logic [MAX_OSR-1:0][CW-1:0] hist_q [DEPTH];
    logic [LW-1:0]              win_len;
    logic [DEPTH-1:0]           in_win;

    assign win_len = LW'(1) << win_sel_i;

    generate
        for (genvar d = 0; d < DEPTH; d++) begin : g_mask
            assign in_win[d] = (LW'(d) < win_len);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < DEPTH; d++) hist_q[d] <= '0;
        end else if (clr_i) begin
            for (int d = 0; d < DEPTH; d++) hist_q[d] <= '0;
        end else if (shift_i) begin
            hist_q[0] <= cnt_i;
            for (int d = 1; d < DEPTH; d++) hist_q[d] <= hist_q[d-1];
        end
    end

    always_comb begin
        sum_o   = '0;
        total_o = '0;
        for (int d = 0; d < DEPTH; d++) begin
            if (in_win[d]) begin
                for (int k = 0; k < MAX_OSR; k++) begin
                    sum_o[k] = sum_o[k] + SW'(hist_q[d][k]);
                    total_o  = total_o + SW'(hist_q[d][k]);
                end
            end
        end
    end

    // R3
    win_total_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        total_o <= SW'(W) * SW'(win_len));

    // R7
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (total_o == '0));
endmodule

// File: rtl/bp_peak_pick.sv
module bp_peak_pick #(
    parameter int MAX_OSR = 10,
    parameter int PW      = 4,
    parameter int SW      = 10
) (
    input  logic [MAX_OSR-1:0][SW-1:0] sum_i,
    input  logic [PW-1:0]              osr_i,
    output logic [PW-1:0]              phase_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [SW-1:0] best_v;
    logic [PW-1:0] idx_v;
    logic [PW:0]   shifted_v;

    always_comb begin
        best_v = '0;
        idx_v  = '0;
        for (int k = 0; k < MAX_OSR; k++) begin
            if (PW'(k) < osr_i && sum_i[k] > best_v) begin
                best_v = sum_i[k];
                idx_v  = PW'(k);
            end
        end
        shifted_v = {1'b0, idx_v} + {2'b00, osr_i[PW-1:1]};
        if (shifted_v >= {1'b0, osr_i}) begin
            shifted_v = shifted_v - {1'b0, osr_i};
        end
        phase_o = shifted_v[PW-1:0];
    end

    // R4
    always_comb begin
        if (osr_i >= PW'(5) && osr_i <= PW'(MAX_OSR)) begin
            phase_range_chk: assert (phase_o < osr_i);
        end
    end
endmodule

// File: rtl/burst_phase_est.sv
module burst_phase_est
    import burst_phase_pkg::*;
#(
    parameter int  W       = 80,
    parameter int  MAX_OSR = 10,
    parameter int  DEPTH   = 8,
    localparam int PW      = $clog2(MAX_OSR + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 burst_start_i,
    input  logic                 eop_i,
    input  logic [PW-1:0]        osr_i,
    input  logic [1:0]           win_sel_i,
    input  logic [W-1:0]         samp_i,
    output logic [PW-1:0]        phase_o,
    output logic                 phase_vld_o,
    output logic                 locked_o,
    output logic                 no_edge_err_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(W + 1);
    localparam int SW = $clog2(W * DEPTH + 1);

    bp_state_e st_q, st_d;

    logic                        prev_q;
    logic [PW-1:0]               off_q;
    logic [PW-1:0]               off_nxt_w;
    logic [MAX_OSR-1:0][CW-1:0]  cnt_w;
    logic [MAX_OSR-1:0][SW-1:0]  sum_w;
    logic [SW-1:0]               total_w;
    logic [PW-1:0]               pick_w;
    logic                        acq_run;
    logic                        latch_now;

    assign acq_run   = (st_q == ST_ACQ) && !burst_start_i;
    assign latch_now = acq_run && eop_i;

    bp_edge_bins #(
        .W(W), .MAX_OSR(MAX_OSR), .PW(PW), .CW(CW)
    ) u_bins (
        .word_i    (samp_i),
        .prev_i    (prev_q),
        .osr_i     (osr_i),
        .off_i     (off_q),
        .cnt_o     (cnt_w),
        .off_nxt_o (off_nxt_w)
    );

    bp_hist_window #(
        .W(W), .MAX_OSR(MAX_OSR), .DEPTH(DEPTH), .CW(CW), .SW(SW)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (burst_start_i),
        .shift_i   (acq_run),
        .win_sel_i (win_sel_i),
        .cnt_i     (cnt_w),
        .sum_o     (sum_w),
        .total_o   (total_w)
    );

    bp_peak_pick #(
        .MAX_OSR(MAX_OSR), .PW(PW), .SW(SW)
    ) u_pick (
        .sum_i   (sum_w),
        .osr_i   (osr_i),
        .phase_o (pick_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (burst_start_i) st_d = ST_ACQ;
            ST_ACQ: begin
                if (burst_start_i)  st_d = ST_ACQ;
                else if (eop_i)     st_d = ST_HOLD;
            end
            ST_HOLD: if (burst_start_i) st_d = ST_ACQ;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_o       <= '0;
            phase_vld_o   <= 1'b0;
            locked_o      <= 1'b0;
            no_edge_err_o <= 1'b0;
            prev_q        <= 1'b0;
            off_q         <= '0;
        end else begin
            prev_q      <= samp_i[W-1];
            phase_vld_o <= 1'b0;
            if (burst_start_i) begin
                off_q         <= '0;
                locked_o      <= 1'b0;
                no_edge_err_o <= 1'b0;
            end else if (acq_run) begin
                off_q <= off_nxt_w;
                if (latch_now) begin
                    phase_vld_o <= 1'b1;
                    locked_o    <= 1'b1;
                    if (total_w == '0) begin
                        no_edge_err_o <= 1'b1;
                    end else begin
                        no_edge_err_o <= 1'b0;
                        phase_o       <= pick_w;
                    end
                end
            end
        end
    end

    // R5
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_vld_o |=> !phase_vld_o);

    // R5
    vld_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_vld_o) |-> ($past(eop_i) && locked_o));

    // R6
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_vld_o |-> $stable(phase_o));

    // R6
    stray_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_i && st_q != ST_ACQ) |=> !phase_vld_o);

    // R7
    start_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start_i |=> (!locked_o && !no_edge_err_o && st_q == ST_ACQ));

    // R8
    err_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_edge_err_o) |-> phase_vld_o);
endmodule

// File: tb/burst_phase_est_tb_top.sv
module burst_phase_est_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bs;
    logic        eop;
    logic [3:0]  osr;
    logic [1:0]  wsel;
    logic [79:0] w80;
    logic [31:0] w32;
    logic [3:0]  ph80, ph32;
    logic        v80, v32, l80, l32, e80, e32;

    int g80, g32, cur_p, cur_pat, cur_osr;
    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    burst_phase_est #(.W(80)) dut_i (
        .clk(clk), .rst_n(rst_n), .burst_start_i(bs), .eop_i(eop),
        .osr_i(osr), .win_sel_i(wsel), .samp_i(w80),
        .phase_o(ph80), .phase_vld_o(v80), .locked_o(l80), .no_edge_err_o(e80));

    burst_phase_est #(.W(32)) dut32_i (
        .clk(clk), .rst_n(rst_n), .burst_start_i(bs), .eop_i(eop),
        .osr_i(osr), .win_sel_i(wsel), .samp_i(w32),
        .phase_o(ph32), .phase_vld_o(v32), .locked_o(l32), .no_edge_err_o(e32));

    // line bit k covers samples [p+(k-1)*osr, p+k*osr); pattern 2 is silent
    function automatic logic sbit(int g, int o, int p, int pat);
        int k;
        k = (g + o - p) / o;
        if (pat == 2) return 1'b0;
        if (pat == 0) return k[0];
        return k[1];
    endfunction

    function automatic int exp_phase(int o, int p);
        return (p + o / 2) % o;
    endfunction

    task automatic check(string req, string what, int got, int expv);
        nchk++;
        if (got != expv) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    task automatic step();
        for (int i = 0; i < 80; i++) w80[i] = sbit(g80 + i, cur_osr, cur_p, cur_pat);
        for (int i = 0; i < 32; i++) w32[i] = sbit(g32 + i, cur_osr, cur_p, cur_pat);
        g80 += 80;
        g32 += 32;
        @(negedge clk);
    endtask

    task automatic start_burst(int o, int ws);
        cur_osr = o;
        osr  = 4'(o);
        wsel = 2'(ws);
        bs   = 1'b1;
        w80  = '0;
        w32  = '0;
        @(negedge clk);
        bs  = 1'b0;
        g80 = 0;
        g32 = 0;
    endtask

    task automatic run(int p, int pat, int n);
        cur_p   = p;
        cur_pat = pat;
        repeat (n) step();
    endtask

    task automatic end_pre();
        eop = 1'b1;
        step();
        eop = 1'b0;
    endtask

    task automatic check_lock(string req, int expph);
        check(req, "vld80", int'(v80), 1);
        check(req, "vld32", int'(v32), 1);
        check(req, "phase80", int'(ph80), expph);
        check(req, "phase32", int'(ph32), expph);
        check(req, "locked80", int'(l80), 1);
        check(req, "err80", int'(e80), 0);
        check(req, "err32", int'(e32), 0);
        step();
        check("R5", "vld80 drop", int'(v80), 0);
        check("R5", "vld32 drop", int'(v32), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int o, p, pat, ws, n;
        void'($urandom(32'd4242));
        rst_n = 1'b0; bs = 1'b0; eop = 1'b0; osr = 4'd5; wsel = 2'd3;
        w80 = '0; w32 = '0; g80 = 0; g32 = 0;
        cur_p = 0; cur_pat = 0; cur_osr = 5;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "phase", int'(ph80), 0);
        check("R1", "vld", int'(v80), 0);
        check("R1", "locked", int'(l80), 0);
        check("R1", "err", int'(e80), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 stray strobe in IDLE
        end_pre();
        check("R6", "idle eop vld", int'(v80), 0);
        check("R6", "idle eop locked", int'(l80), 0);

        // R2, R4, R5 basic burst
        start_burst(5, 3);
        run(2, 0, 20);
        end_pre();
        check_lock("R2/R4", exp_phase(5, 2));

        // R6 stray strobe in HOLD
        end_pre();
        check("R6", "hold eop vld", int'(v80), 0);
        check("R6", "hold phase", int'(ph80), exp_phase(5, 2));
        check("R6", "hold phase32", int'(ph32), exp_phase(5, 2));

        // R3 full tail of new phase inside an 8-cycle window
        start_burst(6, 3);
        run(1, 0, 20);
        run(4, 0, 8);
        end_pre();
        check_lock("R3 tail8", exp_phase(6, 4));

        // R3 short tail: older phase dominates the 8-cycle window
        start_burst(6, 3);
        run(1, 0, 20);
        run(4, 0, 2);
        end_pre();
        check_lock("R3 short", exp_phase(6, 1));

        // R3 one-cycle window sees only the last word
        start_burst(6, 0);
        run(1, 0, 20);
        run(4, 0, 1);
        end_pre();
        check_lock("R3 win1", exp_phase(6, 4));

        // R7 burst start clears history and lock, keeps phase
        start_burst(10, 3);
        run(0, 0, 20);
        end_pre();
        check_lock("R7 first", exp_phase(10, 0));
        start_burst(10, 3);
        check("R7", "locked cleared", int'(l80), 0);
        check("R7", "phase kept", int'(ph80), exp_phase(10, 0));
        run(7, 0, 3);
        end_pre();
        check_lock("R7 fresh", exp_phase(10, 7));

        // R8 silent preamble
        start_burst(5, 2);
        run(0, 2, 10);
        end_pre();
        check("R8", "vld", int'(v80), 1);
        check("R8", "err80", int'(e80), 1);
        check("R8", "err32", int'(e32), 1);
        check("R8", "phase80 held", int'(ph80), exp_phase(10, 7));
        check("R8", "phase32 held", int'(ph32), exp_phase(10, 7));
        step();

        // R9 random ratios, phases, patterns and windows
        for (int it = 0; it < 40; it++) begin
            case ($urandom % 3)
                0: o = 5;
                1: o = 6;
                default: o = 10;
            endcase
            p   = int'($urandom % 32'(o));
            pat = int'($urandom % 2);
            ws  = 2 + int'($urandom % 2);
            n   = 10 + int'($urandom % 20);
            start_burst(o, ws);
            run(p, pat, n);
            end_pre();
            check_lock("R9", exp_phase(o, p));
            repeat (int'($urandom % 3)) step();
        end

        summary();
        $finish;
    end
endmodule